// File: doc/BRIEF.md
# Self-Checking Parity-Predicted Shifter

This block is a purely combinational shifter that moves a data word by any distance from zero to WIDTH-1 in a single evaluation. It can rotate left, shift left with zero fill, shift right with zero fill, or shift right while replicating the sign bit. The shift is built as a cascade of log2(WIDTH) multiplexer stages. Stage i moves the word by 2^i positions when bit i of the distance is set.

The caller supplies the word together with its even-parity bit. The block returns the shifted word and a parity bit for it. That parity bit is predicted, not computed from the result. The predictor takes the incoming parity and corrects it by the parity of the bits pushed out and the parity of the bits pulled in. It uses masks derived only from the shift distance, so no signal is shared with the multiplexer cascade. A two-rail checker compares the real parity of the result with the prediction. Any single fault that flips an odd number of result bits is flagged while the block is in normal use, with no second copy of the shifter.

A test-only port can force any one multiplexer output bit to a chosen value, so that fault detection can be exercised.

Top module: `scs_shifter`

## Requirements
- R1: With op code 2'b00 the result bit j equals input bit (j - amount) mod WIDTH, which is a left rotation, and the number of ones is unchanged.
- R2: With op code 2'b01 the result is the input shifted left by amount positions, and the low amount bits are zero.
- R3: With op code 2'b10 the result is the input shifted right by amount positions, and the high amount bits are zero.
- R4: With op code 2'b11 the result is the input shifted right by amount positions, the high amount bits are copies of input bit WIDTH-1, and the top bit is preserved.
- R5: A shift amount of zero returns the input word unchanged and returns the input parity as the output parity, for every op code.
- R6: The output parity equals the input parity XOR the parity of the discarded bits XOR the parity of the filled bits. Filled bits are zeros for the two logical shifts and copies of the sign bit for the arithmetic shift. A rotation returns the input parity.
- R7: The check output is a two-rail pair, where 2'b01 and 2'b10 mean no error and 2'b00 and 2'b11 mean error. With correct input parity and no injected fault it always reads no error.
- R8: When the supplied input parity is wrong (odd overall parity of word plus parity bit), the check output reads error for every op code and amount.
- R9: With the fault port enabled, the output of stage s, bit b (index s*WIDTH+b, stages counted from the smallest distance) is forced to the fault value. The output parity is unaffected by the fault. The check output reads error exactly when the result differs from the fault-free result in an odd number of bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to shift |
| par_i | input | 1 | Even parity bit of data_i |
| amt_i | input | log2(WIDTH) | Shift distance |
| op_i | input | 2 | 00 rotate left, 01 shift left, 10 shift right, 11 arithmetic shift right |
| flt_en_i | input | 1 | Test only: enable stuck-at override |
| flt_idx_i | input | log2(log2(WIDTH)*WIDTH) | Test only: stage*WIDTH + bit of the forced output |
| flt_val_i | input | 1 | Test only: forced value |
| data_o | output | WIDTH | Shifted word |
| par_o | output | 1 | Predicted parity of data_o |
| chk_o | output | 2 | Two-rail error indication |

## Verification
The assertions watch continuously that fault-free evaluations with consistent input parity give a valid two-rail code. They also check that a bad input parity gives an invalid code, that rotation keeps both the parity and the ones count, that a zero distance is transparent, and that the arithmetic shift keeps the sign bit. Only the bench scenarios can show the exact bit placement of each shift against a reference, and the prediction formula for non-trivial distances. The same holds for the fault campaign, which injects every stage output stuck at either value and confirms that odd-weight corruptions, and only those, are flagged while the predicted parity stays put.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [1:0] {
    SH_ROTL = 2'b00,
    SH_LSL  = 2'b01,
    SH_LSR  = 2'b10,
    SH_ASR  = 2'b11
  } sh_op_e;

  localparam int MAXW = 64;

  // ones in positions below k
  function automatic logic [MAXW-1:0] low_ones(input int k);
    logic [MAXW-1:0] m;
    for (int i = 0; i < MAXW; i++) m[i] = (i < k);
    return m;
  endfunction

endpackage

// File: rtl/scs_shift_stage.sv
module scs_shift_stage
  import scs_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DIST  = 1,
  parameter int STG   = 0,
  parameter int IDXW  = 6
) (
  input  logic [WIDTH-1:0] v_i,
  input  logic             en_i,
  input  sh_op_e           op_i,
  input  logic             flt_en_i,
  input  logic [IDXW-1:0]  flt_idx_i,
  input  logic             flt_val_i,
  output logic [WIDTH-1:0] v_o
);

  localparam logic [WIDTH-1:0] KEEP_L = ~low_ones(DIST)[WIDTH-1:0];
  localparam logic [WIDTH-1:0] KEEP_R = low_ones(WIDTH - DIST)[WIDTH-1:0];

  function automatic logic [WIDTH-1:0] rot_left(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int j = 0; j < WIDTH; j++) r[j] = v[(j - DIST + WIDTH) % WIDTH];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] rot_right(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int j = 0; j < WIDTH; j++) r[j] = v[(j + DIST) % WIDTH];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] move(input logic [WIDTH-1:0] v, input sh_op_e op);
    case (op)
      SH_ROTL: return rot_left(v);
      SH_LSL:  return rot_left(v) & KEEP_L;
      SH_LSR:  return rot_right(v) & KEEP_R;
      SH_ASR:  return (rot_right(v) & KEEP_R) | ({WIDTH{v[WIDTH-1]}} & ~KEEP_R);
      default: return v;
    endcase
  endfunction

  logic [WIDTH-1:0] moved;

  assign moved = en_i ? move(v_i, op_i) : v_i;

  // test-only stuck-at override on this stage's outputs
  always_comb begin
    for (int j = 0; j < WIDTH; j++) begin
      if (flt_en_i && (flt_idx_i == IDXW'(STG * WIDTH + j))) v_o[j] = flt_val_i;
      else                                                  v_o[j] = moved[j];
    end
  end

endmodule

// File: rtl/scs_parity_pred.sv
module scs_parity_pred
  import scs_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SHW   = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             par_i,
  input  logic [SHW-1:0]   amt_i,
  input  sh_op_e           op_i,
  output logic             drop_par_o,
  output logic             fill_par_o,
  output logic             par_o
);

  // bits leaving at the top for a left shift by k
  function automatic logic [WIDTH-1:0] top_mask(input int k);
    return ~low_ones(WIDTH - k)[WIDTH-1:0];
  endfunction

  // bits leaving at the bottom for a right shift by k
  function automatic logic [WIDTH-1:0] bot_mask(input int k);
    return low_ones(k)[WIDTH-1:0];
  endfunction

  always_comb begin
    drop_par_o = 1'b0;
    fill_par_o = 1'b0;
    case (op_i)
      SH_ROTL: begin
        drop_par_o = 1'b0;
        fill_par_o = 1'b0;
      end
      SH_LSL:  drop_par_o = ^(data_i & top_mask(int'(amt_i)));
      SH_LSR:  drop_par_o = ^(data_i & bot_mask(int'(amt_i)));
      SH_ASR: begin
        drop_par_o = ^(data_i & bot_mask(int'(amt_i)));
        fill_par_o = data_i[WIDTH-1] & amt_i[0];
      end
      default: ;
    endcase
  end

  assign par_o = par_i ^ drop_par_o ^ fill_par_o;

endmodule

// File: rtl/scs_tr_checker.sv
module scs_tr_checker #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic             pred_i,
  output logic             res_par_o,
  output logic [1:0]       pair_o
);

  assign res_par_o = ^word_i;
  // complementary rails when real and predicted parity agree
  assign pair_o    = {res_par_o, ~pred_i};

endmodule

// File: rtl/scs_shifter.sv
module scs_shifter
  import scs_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SHW  = $clog2(WIDTH),
  localparam int FIW  = $clog2(SHW * WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             par_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic [1:0]       op_i,
  input  logic             flt_en_i,
  input  logic [FIW-1:0]   flt_idx_i,
  input  logic             flt_val_i,
  output logic [WIDTH-1:0] data_o,
  output logic             par_o,
  output logic [1:0]       chk_o
);

  sh_op_e           op;
  logic [WIDTH-1:0] stage_v [0:SHW];
  logic             drop_par;
  logic             fill_par;
  logic             pred_par;
  logic             res_par;

  assign op         = sh_op_e'(op_i);
  assign stage_v[0] = data_i;

  for (genvar g = 0; g < SHW; g++) begin : g_stage
    scs_shift_stage #(
      .WIDTH (WIDTH),
      .DIST  (1 << g),
      .STG   (g),
      .IDXW  (FIW)
    ) stage_i (
      .v_i       (stage_v[g]),
      .en_i      (amt_i[g]),
      .op_i      (op),
      .flt_en_i  (flt_en_i),
      .flt_idx_i (flt_idx_i),
      .flt_val_i (flt_val_i),
      .v_o       (stage_v[g+1])
    );
  end

  scs_parity_pred #(
    .WIDTH (WIDTH),
    .SHW   (SHW)
  ) pred_i (
    .data_i     (data_i),
    .par_i      (par_i),
    .amt_i      (amt_i),
    .op_i       (op),
    .drop_par_o (drop_par),
    .fill_par_o (fill_par),
    .par_o      (pred_par)
  );

  scs_tr_checker #(
    .WIDTH (WIDTH)
  ) chk_i (
    .word_i    (stage_v[SHW]),
    .pred_i    (pred_par),
    .res_par_o (res_par),
    .pair_o    (chk_o)
  );

  assign data_o = stage_v[SHW];
  assign par_o  = pred_par;

endmodule

// File: rtl/scs_shifter_sva.sv
module scs_shifter_sva #(
  parameter int WIDTH = 16,
  localparam int SHW  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_i,
  input logic             par_i,
  input logic [SHW-1:0]   amt_i,
  input logic [1:0]       op_i,
  input logic             flt_en_i,
  input logic [WIDTH-1:0] data_o,
  input logic             par_o,
  input logic [1:0]       chk_o,
  input logic             res_par,
  input logic             pred_par
);

  logic known;
  logic clean;
  logic good_in;

  assign known   = !$isunknown({data_i, par_i, amt_i, op_i, flt_en_i, data_o, par_o, chk_o});
  assign clean   = known && !flt_en_i;
  assign good_in = (par_i == ^data_i);

  always_comb begin
    if (clean && good_in) begin
      // R7
      tr_valid_chk: assert (chk_o[0] != chk_o[1]);
    end
    if (clean && !good_in) begin
      // R8
      bad_par_chk: assert (chk_o[0] == chk_o[1]);
    end
    if (known && op_i == 2'b00) begin
      // R6
      rot_par_chk: assert (par_o == par_i);
    end
    if (clean && op_i == 2'b00) begin
      // R1
      rot_pop_chk: assert ($countones(data_o) == $countones(data_i));
    end
    if (clean && amt_i == '0) begin
      // R5
      zero_amt_chk: assert (data_o == data_i && par_o == par_i);
    end
    if (clean && op_i == 2'b11) begin
      // R4
      sra_msb_chk: assert (data_o[WIDTH-1] == data_i[WIDTH-1]);
    end
    if (clean) begin
      // R7
      rail_src_chk: assert (chk_o == {res_par, ~pred_par});
    end
  end

endmodule

bind scs_shifter scs_shifter_sva #(.WIDTH(WIDTH)) sva_i (
  .data_i   (data_i),
  .par_i    (par_i),
  .amt_i    (amt_i),
  .op_i     (op_i),
  .flt_en_i (flt_en_i),
  .data_o   (data_o),
  .par_o    (par_o),
  .chk_o    (chk_o),
  .res_par  (res_par),
  .pred_par (pred_par)
);

// File: tb/scs_shifter_tb_top.sv
module scs_shifter_tb_top;

  localparam int W  = 16;
  localparam int SW = $clog2(W);
  localparam int FW = $clog2(SW * W);

  logic          clk = 1'b0;
  logic [W-1:0]  data_i;
  logic          par_i;
  logic [SW-1:0] amt_i;
  logic [1:0]    op_i;
  logic          flt_en_i;
  logic [FW-1:0] flt_idx_i;
  logic          flt_val_i;
  logic [W-1:0]  data_o;
  logic          par_o;
  logic [1:0]    chk_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  scs_shifter #(.WIDTH(W)) dut_i (
    .data_i    (data_i),
    .par_i     (par_i),
    .amt_i     (amt_i),
    .op_i      (op_i),
    .flt_en_i  (flt_en_i),
    .flt_idx_i (flt_idx_i),
    .flt_val_i (flt_val_i),
    .data_o    (data_o),
    .par_o     (par_o),
    .chk_o     (chk_o)
  );

  // behavioural reference: bit-by-bit source selection
  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int k, input int op);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) begin
      case (op)
        0: r[j] = d[(j - k + W) % W];
        1: r[j] = (j >= k) ? d[(j - k + W) % W] : 1'b0;
        2: r[j] = (j + k < W) ? d[(j + k) % W] : 1'b0;
        default: r[j] = (j + k < W) ? d[(j + k) % W] : d[W-1];
      endcase
    end
    return r;
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic p, input int k, input int op,
                       input logic fe, input int fi, input logic fv);
    @(negedge clk);
    data_i    = d;
    par_i     = p;
    amt_i     = SW'(k);
    op_i      = 2'(op);
    flt_en_i  = fe;
    flt_idx_i = FW'(fi);
    flt_val_i = fv;
    @(posedge clk);
    #1;
  endtask

  task automatic run_vec(input logic [W-1:0] d, input int k, input int op, input bit bad);
    logic [W-1:0] exp_d;
    logic         exp_p;
    apply(d, (^d) ^ bad, k, op, 1'b0, 0, 1'b0);
    exp_d = model(d, k, op);
    exp_p = (^exp_d) ^ bad;
    check(data_o == exp_d, (k == 0) ? "R5" : op_tag(op), 64'(data_o), 64'(exp_d));
    check(par_o == exp_p, "R6", 64'(par_o), 64'(exp_p));
    if (bad) check(chk_o[0] == chk_o[1], "R8", 64'(chk_o), 64'(2'b00));
    else     check(chk_o[0] != chk_o[1], "R7", 64'(chk_o), 64'(2'b01));
  endtask

  initial begin
    logic [W-1:0] pats [5];
    data_i = '0; par_i = 1'b0; amt_i = '0; op_i = '0;
    flt_en_i = 1'b0; flt_idx_i = '0; flt_val_i = 1'b0;

    // idle state: all-zero word, R7 valid code
    apply('0, 1'b0, 0, 0, 1'b0, 0, 1'b0);
    check(data_o == '0, "R5", 64'(data_o), 64'(0));
    check(chk_o[0] != chk_o[1], "R7", 64'(chk_o), 64'(2'b01));

    pats[0] = 16'h8001; pats[1] = 16'hffff; pats[2] = 16'ha5c3;
    pats[3] = 16'h7ffe; pats[4] = W'($urandom);
    // R1 R2 R3 R4 R5 R6 R7 over every distance and op
    for (int p = 0; p < 5; p++)
      for (int op = 0; op < 4; op++)
        for (int k = 0; k < W; k++)
          run_vec(pats[p], k, op, 1'b0);

    // R8: wrong input parity
    for (int n = 0; n < 32; n++) run_vec(W'($urandom), n % W, n % 4, 1'b1);

    // R9: single stuck-at on every stage output, both polarities
    for (int s = 0; s < SW; s++)
      for (int b = 0; b < W; b++)
        for (int v = 0; v < 2; v++) begin
          logic [W-1:0] d;
          logic [W-1:0] exp_d;
          int           k;
          int           op;
          int           diffs;
          d  = W'($urandom);
          k  = (s * 5 + b) % W;
          op = (s + b + v) % 4;
          apply(d, ^d, k, op, 1'b1, s * W + b, v[0]);
          exp_d = model(d, k, op);
          diffs = $countones(data_o ^ exp_d);
          check(par_o == ^exp_d, "R9", 64'(par_o), 64'(^exp_d));
          check((chk_o[0] == chk_o[1]) == diffs[0], "R9",
                64'(chk_o), diffs[0] ? 64'(2'b00) : 64'(2'b01));
        end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule